// File: doc/BRIEF.md
# Interrupt Aggregator with Configurable Output Pin

This block gathers single-cycle event strobes from up to 32 interrupt sources and records each one in a sticky status word. The sources are the endpoints plus six bus conditions: frame start, missed frame start, transfer end, suspend, resume and bus reset. A 32-bit enable mask decides which recorded events may drive one shared interrupt pin. Software clears status bits by writing ones through an acknowledge port.

The pin's active level can be set high or low. It runs in one of two modes. In level mode it stays asserted while any enabled status bit is set. In pulse mode each enabled event strobe produces a fixed pulse of `PULSE_CYCLES` clocks. With the default of 8 clocks at 48 MHz the pulse lasts about 166 ns. The enable mask is held across a bus reset, which only records a status event.

Top module: `int_aggregator`

## Requirements
- R1: After hardware reset `en_o` is all zeros. A cycle with `en_we_i` high loads `en_wdata_i` into the mask, and the new value shows on `en_o` after that clock edge. Without a write the mask holds its value.
- R2: An event strobe on `event_i[i]` sets `status_o[i]` from the next cycle onward, whether or not enable bit i is set. Set bits remain set until they are cleared.
- R3: A cycle with `clr_we_i` high clears every status bit whose `clr_mask_i` bit is 1, writing one to clear. If an event strobe hits the same bit in that cycle, the event wins and the bit stays set.
- R4: Bus reset is source bit 31, and it sets `status_o[31]` like any other event. It never changes the enable mask. The other fixed bus sources are bit 26 (frame start), 27 (missed frame start), 28 (transfer end), 29 (suspend) and 30 (resume); bits 25..0 are endpoints.
- R5: Polarity bit 0 makes the pin active low, so it idles at 1. Polarity bit 1 makes it active high, so it idles at 0.
- R6: In level mode the pin is active exactly when some status bit is both set and enabled. Set but disabled bits leave the pin inactive.
- R7: In pulse mode, if the pin is idle when an enabled event strobe arrives, the pin is active for exactly `PULSE_CYCLES` (default 8) consecutive cycles, starting the next cycle.
- R8: In pulse mode, enabled events that arrive while a pulse is running merge into that pulse. They neither extend it nor restart it. After the pulse ends, a new enabled event starts a new pulse.
- R9: After hardware reset the polarity is active low and level mode is selected. `cfg_we_i` loads `cfg_pol_i` (1 = active high) and `cfg_pulse_i` (1 = pulse mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| event_i | input | 32 | Event strobes, one per source |
| en_we_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 32 | Enable mask write data |
| cfg_we_i | input | 1 | Pin configuration write strobe |
| cfg_pol_i | input | 1 | Pin polarity (1 = active high) |
| cfg_pulse_i | input | 1 | Pin mode (1 = pulsed) |
| clr_we_i | input | 1 | Status acknowledge strobe |
| clr_mask_i | input | 32 | Status bits to clear |
| status_o | output | 32 | Latched status word |
| en_o | output | 32 | Current enable mask |
| irq_o | output | 1 | Interrupt pin |

## Verification
Level mode is exercised in three ways: events on disabled sources, events on enabled sources, and acknowledge cycles that collide with new strobes. Together these show whether masking and write-one-to-clear priority are correct. Pulse mode is exercised with three patterns: a single strobe, a second strobe inside a running pulse, and a strobe after the pulse has ended. These show an exact pulse width apart from merging and re-triggering. A bus-reset strobe with a non-zero mask checks that the mask survives. Both polarities are visited in both modes.

// File: rtl/int_agg_pkg.sv
package int_agg_pkg;
  localparam int unsigned SRC_SOF      = 26;
  localparam int unsigned SRC_SOF_LOST = 27;
  localparam int unsigned SRC_EOT      = 28;
  localparam int unsigned SRC_SUSPEND  = 29;
  localparam int unsigned SRC_RESUME   = 30;
  localparam int unsigned SRC_BUS_RST  = 31;

  typedef struct packed {
    logic pol;    // 1: active high
    logic pulse;  // 1: pulsed signalling
  } pin_cfg_t;
endpackage

// File: rtl/int_status_bank.sv
module int_status_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        bit_q <= 1'b0;
      else if (set_i[i])                  bit_q <= 1'b1;  // set wins over clear
      else if (clr_we_i && clr_mask_i[i]) bit_q <= 1'b0;
    end
    assign stat_o[i] = bit_q;
  end
endmodule

// File: rtl/int_pulse_gen.sv
module int_pulse_gen #(
  parameter int unsigned LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!mode_i)                  cnt_q <= '0;
    else if (cnt_q == '0 && trig_i)    cnt_q <= CW'(LEN);
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/int_pin_drive.sv
module int_pin_drive
  import int_agg_pkg::*;
(
  input  pin_cfg_t cfg_i,
  input  logic     level_act_i,
  input  logic     pulse_act_i,
  output logic     pin_o
);
  logic act;
  assign act   = cfg_i.pulse ? pulse_act_i : level_act_i;
  assign pin_o = cfg_i.pol ? act : ~act;
endmodule

// File: rtl/int_aggregator.sv
module int_aggregator
  import int_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 32,
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               cfg_we_i,
  input  logic               cfg_pol_i,
  input  logic               cfg_pulse_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] en_q;
  pin_cfg_t           cfg_q;
  logic               level_act, pulse_act, trig;

  // mask is touched only by its write port; bus reset is just an event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= '{pol: cfg_pol_i, pulse: cfg_pulse_i};
  end

  int_status_bank #(.N(NUM_SRC)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (event_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .stat_o     (status_o)
  );

  assign level_act = |(status_o & en_q);
  assign trig      = |(event_i & en_q);

  int_pulse_gen #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (cfg_q.pulse),
    .trig_i   (trig),
    .active_o (pulse_act)
  );

  int_pin_drive u_pin (
    .cfg_i       (cfg_q),
    .level_act_i (level_act),
    .pulse_act_i (pulse_act),
    .pin_o       (irq_o)
  );

  assign en_o = en_q;
endmodule

// File: rtl/int_aggregator_chk.sv
module int_aggregator_chk #(
  parameter int unsigned NUM_SRC      = 32,
  parameter int unsigned PULSE_CYCLES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] event_i,
  input logic               en_we_i,
  input logic               cfg_we_i,
  input logic               clr_we_i,
  input logic [NUM_SRC-1:0] clr_mask_i,
  input logic [NUM_SRC-1:0] status_o,
  input logic [NUM_SRC-1:0] en_o,
  input logic               irq_o,
  input logic               pol,
  input logic               pulse
);
  logic act;
  int unsigned run_q;
  assign act = (irq_o == pol);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= 0;
    else if (pulse && act) run_q <= run_q + 1;
    else                   run_q <= 0;
  end

  assert_mask_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_o));

  assert_event_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(event_i)) == $past(event_i)));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_o & $past(clr_mask_i & ~event_i)) == '0));

  assert_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse |-> (act == (|(status_o & en_o))));

  assert_pulse_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse && !cfg_we_i && !act && |(event_i & en_o)) |=> act);

  assert_pulse_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= PULSE_CYCLES);
endmodule

bind int_aggregator int_aggregator_chk #(
  .NUM_SRC(NUM_SRC), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .event_i    (event_i),
  .en_we_i    (en_we_i),
  .cfg_we_i   (cfg_we_i),
  .clr_we_i   (clr_we_i),
  .clr_mask_i (clr_mask_i),
  .status_o   (status_o),
  .en_o       (en_o),
  .irq_o      (irq_o),
  .pol        (cfg_q.pol),
  .pulse      (cfg_q.pulse)
);

// File: tb/int_aggregator_bench.sv
`timescale 1ns/1ps
module int_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] event_s = '0, en_wdata = '0, clr_mask = '0;
  logic        en_we = 1'b0, cfg_we = 1'b0, cfg_pol = 1'b0, cfg_pulse = 1'b0, clr_we = 1'b0;
  logic [31:0] status, en;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  int_aggregator u_int_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .event_i(event_s),
    .en_we_i(en_we), .en_wdata_i(en_wdata),
    .cfg_we_i(cfg_we), .cfg_pol_i(cfg_pol), .cfg_pulse_i(cfg_pulse),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .status_o(status), .en_o(en), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_st = '0, m_en = '0;
  bit m_pol = 0, m_pls = 0;
  int m_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_pol = 0; m_pls = 0; m_left = 0;
    end else begin
      bit trig;
      trig = (event_s & m_en) != 0;
      if (!m_pls) m_left = 0;
      else if (m_left == 0 && trig) m_left = 8;
      else if (m_left > 0) m_left = m_left - 1;
      if (clr_we) m_st = m_st & ~clr_mask;
      m_st = m_st | event_s;
      if (en_we) m_en = en_wdata;
      if (cfg_we) begin m_pol = cfg_pol; m_pls = cfg_pulse; end
    end
  end

  function automatic bit m_irq();
    bit a;
    a = m_pls ? (m_left > 0) : ((m_st & m_en) != 0);
    return m_pol ? a : ~a;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check("R2/R3 status vs model", status, m_st);
    check("R1/R4 mask vs model", en, m_en);
    check("R5/R6/R7 pin vs model", {31'd0, irq}, {31'd0, m_irq()});
  endtask

  task automatic pulse_ev(logic [31:0] ev);
    event_s = ev; cyc(); event_s = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 R9 R5: reset state
    check("R1 mask reset", en, 32'h0);
    check("R2 status reset", status, 32'h0);
    check("R9 R5 pin idles high", {31'd0, irq}, 32'd1);
    rst_n = 1'b1;
    cyc();

    // R2 R6: disabled event latches, pin stays idle
    pulse_ev(32'h0000_0005);
    check("R2 latched while disabled", status, 32'h0000_0005);
    check("R6 disabled bits do not drive", {31'd0, irq}, 32'd1);

    // R1 R6: enable one set bit -> active low
    en_wdata = 32'h0000_0004; en_we = 1; cyc(); en_we = 0;
    check("R1 mask written", en, 32'h0000_0004);
    check("R6 level active low", {31'd0, irq}, 32'd0);
    cyc();
    check("R6 level held", {31'd0, irq}, 32'd0);

    // R3: clear enabled bit -> pin released, other bit kept
    clr_mask = 32'h0000_0004; clr_we = 1; cyc(); clr_we = 0;
    check("R3 w1c clears", status, 32'h0000_0001);
    check("R6 released after clear", {31'd0, irq}, 32'd1);

    // R3: set wins over clear in same cycle
    clr_mask = 32'h0000_0003; clr_we = 1; event_s = 32'h0000_0002; cyc();
    clr_we = 0; event_s = '0;
    check("R3 event beats clear", status, 32'h0000_0002);

    // R4: bus reset event with mask set keeps mask
    en_wdata = 32'hC000_00F0; en_we = 1; cyc(); en_we = 0;
    pulse_ev(32'h8000_0000);
    check("R4 bus reset latched", status[31], 1'b1);
    check("R4 mask survives bus reset", en, 32'hC000_00F0);
    check("R6 bus reset enabled drives pin", {31'd0, irq}, 32'd0);

    // R5: polarity high in level mode
    cfg_pol = 1; cfg_pulse = 0; cfg_we = 1; cyc(); cfg_we = 0;
    check("R5 active high", {31'd0, irq}, 32'd1);
    clr_mask = '1; clr_we = 1; cyc(); clr_we = 0;
    check("R5 idle low", {31'd0, irq}, 32'd0);

    // R7: pulse mode, single event, count width
    cfg_pol = 1; cfg_pulse = 1; cfg_we = 1; cyc(); cfg_we = 0;
    pulse_ev(32'h0000_0010);
    cnt = 0;
    while (irq && cnt < 20) begin cnt++; cyc(); end
    check("R7 pulse width", cnt, 8);

    // R8: merge event inside pulse
    pulse_ev(32'h0000_0020);
    cnt = 1;
    cyc(); cyc();
    event_s = 32'h0000_0040; cyc(); event_s = '0;
    cnt = cnt + 3;
    while (irq && cnt < 20) begin cnt++; cyc(); end
    check("R8 merged pulse width", cnt, 9);  // 8 active + first idle sample
    // R8: new event after end retriggers
    pulse_ev(32'h0000_0080);
    check("R8 retrigger", {31'd0, irq}, 32'd1);
    repeat (10) cyc();
    // R7: disabled event in pulse mode gives no pulse
    pulse_ev(32'h0000_0100);
    check("R7 disabled no pulse", {31'd0, irq}, 32'd0);

    // R5 R7: active-low pulse
    cfg_pol = 0; cfg_pulse = 1; cfg_we = 1; cyc(); cfg_we = 0;
    pulse_ev(32'h4000_0000);
    check("R5 R7 active-low pulse", {31'd0, irq}, 32'd0);
    repeat (9) cyc();
    check("R7 pulse ended", {31'd0, irq}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule